// File: doc/BRIEF.md
# Bus Ownership Requester

This block wins ownership of a shared, daisy-chain arbitrated backplane bus on behalf of one local master. The master raises a want-bus line. The block then drives one of four request lines and waits for the grant that travels down the chain. Once the grant arrives and the previous owner has let go of the busy line, the block takes the busy line and answers the master with a grant of its own. Grants that arrive while the block is not requesting on that line are passed on to the next slot.

Two configuration bits set the behaviour. The request bit picks between fair and demand requesting. A fair requester waits until its own request line is quiet before it asks. A demand requester asks at once. The release bit picks between two policies. Under release-when-done, the block lets go of the bus when the master's access ends. Under release-on-request, the block keeps the busy line as long as nobody else is asking, so a later local access can use the bus again without a new arbitration. A two-bit field selects the request line. The block samples this field when a request starts.

All lines are active-high at this block's edge. The bus drivers that invert them for the backplane sit outside. The master keeps want-bus high from the moment it raises it until it receives the grant.

Top module: `vmeReqTop`

## Requirements
- R1: While reset is held and on the first cycle after it, no request line, the busy line and the master grant are all low.
- R2: With fair mode off, one cycle after want-bus is sampled high in idle, exactly one request line is high: bit `cfgLevel` of `busReqOut`. This holds whatever `busReqIn` shows.
- R3: With fair mode on, the block does not drive its request while `busReqIn[level]` is high. Its request rises one cycle after that bit is sampled low.
- R4: While requesting, a grant on the block's own line (`busGrantIn[level]`) is taken only in a cycle where `bbsyIn` is low. One cycle after it is taken, `bbsyOut` and `devGrantBus` are high and `busReqOut` is zero. A grant seen while `bbsyIn` is high is ignored.
- R5: `busGrantOut[i]` equals `busGrantIn[i]` for every line i. The one exception is the block's own line while it is requesting: that grant is absorbed and `busGrantOut` on that line is 0.
- R6: With the release bit 0, one cycle after want-bus is sampled low while the block owns the bus, both `bbsyOut` and `devGrantBus` are low.
- R7: With the release bit 1, if any bit of `busReqIn` is high in the cycle the master drops want-bus, `bbsyOut` falls one cycle later.
- R8: With the release bit 1 and `busReqIn` all zero when want-bus drops, `bbsyOut` stays high and `devGrantBus` goes low. A later want-bus, with `busReqIn` still zero, brings back `devGrantBus` one cycle later and drives no request line.
- R9: While the bus is kept in this way (`bbsyOut` high, `devGrantBus` low), any high bit on `busReqIn` releases `bbsyOut` one cycle later.
- R10: The request line is fixed when the request starts. A later change of `cfgLevel` does not move it until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLevel | input | 2 | Request line to use (0..3) |
| cfgFair | input | 1 | 1 = fair requesting, 0 = demand |
| cfgRelOnReq | input | 1 | 1 = release on request, 0 = release when done |
| devWantBus | input | 1 | Local master wants the bus |
| devGrantBus | output | 1 | Local master may run its cycle |
| busReqIn | input | 4 | Request lines as driven by other masters |
| busReqOut | output | 4 | This block's request lines |
| bbsyIn | input | 1 | Busy line held by another owner |
| bbsyOut | output | 1 | This block holds the bus busy |
| busGrantIn | input | 4 | Daisy-chain grants arriving from upstream |
| busGrantOut | output | 4 | Daisy-chain grants passed downstream |

## Verification
The bench targets four kinds of mistake. The first is a fair requester that asks while its own line is busy. A design with this fault shows a request rising one cycle after a sampled busy bit. The second is a grant taken while the old owner still holds busy, which would show two owners on the bus. The third is the kept-bus state. A design that gets it wrong either re-arbitrates for a local access that needs no arbitration, or holds the bus after another master has started asking. The fourth is the daisy chain. Directed cases pass grants on lines the block is not using while it absorbs its own, and they change the configured level in the middle of a request, where a fault moves the request line. Random traffic then mixes these cases under a reference model that follows the requirements.

// File: rtl/vmeReqPkg.sv
package vmeReqPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_REQ   = 3'd2,
    ST_OWN   = 3'd3,
    ST_KEEP  = 3'd4
  } reqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLevel;
    logic driveReq;
    logic holdBusy;
    logic grantDev;
  } reqCtrlT;

  // conditions from datapath to control
  typedef struct packed {
    logic pendAtCfg;
    logic pendAtLevel;
    logic pendAny;
    logic grantHere;
  } reqStatT;

endpackage

// File: rtl/vmeReqCtrl.sv
module vmeReqCtrl
  import vmeReqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgFair,
  input  logic    cfgRelOnReq,
  input  logic    devWantBus,
  input  logic    bbsyIn,
  input  reqStatT stat,
  output reqCtrlT ctrl
);

  reqStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (devWantBus) begin
          if (cfgFair && stat.pendAtCfg) stateD = ST_WAIT;
          else                           stateD = ST_REQ;
        end
      end
      ST_WAIT: begin
        if (!devWantBus)            stateD = ST_IDLE;
        else if (!stat.pendAtLevel) stateD = ST_REQ;
      end
      ST_REQ: begin
        if (stat.grantHere && !bbsyIn) stateD = ST_OWN;
      end
      ST_OWN: begin
        if (!devWantBus) begin
          if (cfgRelOnReq && !stat.pendAny) stateD = ST_KEEP;
          else                              stateD = ST_IDLE;
        end
      end
      ST_KEEP: begin
        if (stat.pendAny)     stateD = ST_IDLE;
        else if (devWantBus)  stateD = ST_OWN;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctrl.loadLevel = (stateQ == ST_IDLE) && devWantBus;
    ctrl.driveReq  = (stateQ == ST_REQ);
    ctrl.holdBusy  = (stateQ == ST_OWN) || (stateQ == ST_KEEP);
    ctrl.grantDev  = (stateQ == ST_OWN);
  end

endmodule

// File: rtl/vmeReqData.sv
module vmeReqData
  import vmeReqPkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int DEFAULT_LEVEL = 3,
  localparam int LVL_W        = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LVL_W-1:0]      cfgLevel,
  input  logic [NUM_LEVELS-1:0] busReqIn,
  input  logic [NUM_LEVELS-1:0] busGrantIn,
  input  reqCtrlT               ctrl,
  output reqStatT               stat,
  output logic [NUM_LEVELS-1:0] busReqOut,
  output logic [NUM_LEVELS-1:0] busGrantOut,
  output logic                  bbsyOut,
  output logic                  devGrantBus
);

  logic [LVL_W-1:0]      levelQ;
  logic [NUM_LEVELS-1:0] levelHot;
  logic [NUM_LEVELS-1:0] cfgHot;
  logic [NUM_LEVELS-1:0] reqMask;

  always_ff @(posedge clk) begin
    if (!rstN)               levelQ <= LVL_W'(DEFAULT_LEVEL);
    else if (ctrl.loadLevel) levelQ <= cfgLevel;
  end

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_decode
    assign levelHot[i] = (levelQ == LVL_W'(i));
    assign cfgHot[i]   = (cfgLevel == LVL_W'(i));
    assign reqMask[i]  = ctrl.driveReq && levelHot[i];
  end

  always_comb begin
    stat.pendAtCfg   = |(busReqIn & cfgHot);
    stat.pendAtLevel = |(busReqIn & levelHot);
    stat.pendAny     = |busReqIn;
    stat.grantHere   = |(busGrantIn & levelHot);
  end

  assign busReqOut   = reqMask;
  assign busGrantOut = busGrantIn & ~reqMask;
  assign bbsyOut     = ctrl.holdBusy;
  assign devGrantBus = ctrl.grantDev;

endmodule

// File: rtl/vmeReqTop.sv
module vmeReqTop
  import vmeReqPkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int DEFAULT_LEVEL = 3,
  localparam int LVL_W        = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LVL_W-1:0]      cfgLevel,
  input  logic                  cfgFair,
  input  logic                  cfgRelOnReq,
  input  logic                  devWantBus,
  output logic                  devGrantBus,
  input  logic [NUM_LEVELS-1:0] busReqIn,
  output logic [NUM_LEVELS-1:0] busReqOut,
  input  logic                  bbsyIn,
  output logic                  bbsyOut,
  input  logic [NUM_LEVELS-1:0] busGrantIn,
  output logic [NUM_LEVELS-1:0] busGrantOut
);

  reqCtrlT ctrl;
  reqStatT stat;

  vmeReqCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgFair     (cfgFair),
    .cfgRelOnReq (cfgRelOnReq),
    .devWantBus  (devWantBus),
    .bbsyIn      (bbsyIn),
    .stat        (stat),
    .ctrl        (ctrl)
  );

  vmeReqData #(
    .NUM_LEVELS    (NUM_LEVELS),
    .DEFAULT_LEVEL (DEFAULT_LEVEL)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLevel    (cfgLevel),
    .busReqIn    (busReqIn),
    .busGrantIn  (busGrantIn),
    .ctrl        (ctrl),
    .stat        (stat),
    .busReqOut   (busReqOut),
    .busGrantOut (busGrantOut),
    .bbsyOut     (bbsyOut),
    .devGrantBus (devGrantBus)
  );

endmodule

// File: rtl/vmeReqChecker.sv
module vmeReqChecker #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [LVL_W-1:0]      cfgLevel,
  input logic                  cfgFair,
  input logic                  cfgRelOnReq,
  input logic                  devWantBus,
  input logic                  devGrantBus,
  input logic [NUM_LEVELS-1:0] busReqIn,
  input logic [NUM_LEVELS-1:0] busReqOut,
  input logic                  bbsyIn,
  input logic                  bbsyOut,
  input logic [NUM_LEVELS-1:0] busGrantIn,
  input logic [NUM_LEVELS-1:0] busGrantOut
);

  assert_one_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busReqOut));

  assert_fair_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(|busReqOut) && $past(cfgFair)) |-> (($past(busReqIn) & busReqOut) == '0));

  assert_no_req_when_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    !((|busReqOut) && bbsyOut));

  assert_grant_needs_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    devGrantBus |-> bbsyOut);

  assert_grant_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(devGrantBus) && $past(|busReqOut))
      |-> (!$past(bbsyIn) && ($past(busGrantIn & busReqOut) != '0)));

  assert_chain_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busGrantOut & ~busGrantIn) == '0);

  assert_release_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devGrantBus) && !$past(cfgRelOnReq)) |-> !bbsyOut);

  assert_release_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devGrantBus) && $past(|busReqIn)) |-> !bbsyOut);

  assert_reuse_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(devGrantBus) && $past(bbsyOut)) |-> !$past(|busReqIn));

  assert_kept_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bbsyOut && !devGrantBus && (|busReqIn)) |=> !bbsyOut);

  assert_level_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|busReqOut) && $past(|busReqOut)) |-> (busReqOut == $past(busReqOut)));

endmodule

bind vmeReqTop vmeReqChecker #(.NUM_LEVELS(NUM_LEVELS)) chk_i (.*);

// File: tb/vmeReqTop_tb.sv
module vmeReqTop_tb_top;

  localparam int S_IDLE = 0, S_WAIT = 1, S_REQ = 2, S_OWN = 3, S_KEEP = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cfgLevel;
  logic       cfgFair, cfgRelOnReq, devWantBus, bbsyIn;
  logic [3:0] busReqIn, busGrantIn;
  logic       devGrantBus, bbsyOut;
  logic [3:0] busReqOut, busGrantOut;

  int checks = 0;
  int fails  = 0;
  int mState = S_IDLE;
  int mLvl   = 3;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  vmeReqTop dut_i (.*);

  function automatic int nextState(int s);
    int n = s;
    case (s)
      S_IDLE: if (devWantBus) n = (cfgFair && busReqIn[cfgLevel]) ? S_WAIT : S_REQ;
      S_WAIT: if (!devWantBus) n = S_IDLE; else if (!busReqIn[mLvl]) n = S_REQ;
      S_REQ:  if (busGrantIn[mLvl] && !bbsyIn) n = S_OWN;
      S_OWN:  if (!devWantBus) n = (cfgRelOnReq && busReqIn == 4'd0) ? S_KEEP : S_IDLE;
      S_KEEP: if (busReqIn != 4'd0) n = S_IDLE; else if (devWantBus) n = S_OWN;
      default: n = S_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [3:0] expReq();
    return (mState == S_REQ) ? (4'd1 << mLvl) : 4'd0;
  endfunction

  task automatic chk(string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (state %0d)", tag, what, act, exp, mState);
    end
  endtask

  task automatic checkAll();
    chk("busReqOut", busReqOut, expReq());
    chk("bbsyOut", {3'd0, bbsyOut}, {3'd0, (mState == S_OWN || mState == S_KEEP)});
    chk("devGrantBus", {3'd0, devGrantBus}, {3'd0, (mState == S_OWN)});
    chk("busGrantOut R5", busGrantOut, busGrantIn & ~expReq());
  endtask

  task automatic tick();
    int n;
    if (mState == S_IDLE && devWantBus) mLvl = int'(cfgLevel);
    n = nextState(mState);
    @(posedge clk);
    mState = n;
    @(negedge clk);
    checkAll();
  endtask

  task automatic quiet();
    devWantBus = 0; busReqIn = 0; busGrantIn = 0; bbsyIn = 0;
  endtask

  task automatic toIdle();
    quiet();
    cfgRelOnReq = 0;
    busReqIn = 4'b0001;
    for (int i = 0; i < 4; i++) tick();
    busReqIn = 0;
    tick();
  endtask

  task automatic gainBus(logic [1:0] lvl);
    cfgLevel = lvl; busReqIn = 0; devWantBus = 1; bbsyIn = 0;
    busGrantIn = 4'd1 << lvl;
    for (int i = 0; i < 4 && mState != S_OWN; i++) tick();
    busGrantIn = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rstN = 0; cfgLevel = 2'd3; cfgFair = 0; cfgRelOnReq = 0;
    quiet();
    busGrantIn = 4'b1010;
    repeat (3) @(negedge clk);
    // R1: reset state, grants pass through
    tag = "R1";
    checkAll();
    rstN = 1;
    tick();
    busGrantIn = 0;
    tick();

    // R2: demand request ignores busy line at its level
    tag = "R2";
    cfgFair = 0; cfgLevel = 2'd2; busReqIn = 4'b0100; devWantBus = 1;
    tick(); tick();
    // R5: foreign grants pass, own grant absorbed; R4: held off by bbsyIn
    tag = "R4";
    busReqIn = 0; bbsyIn = 1; busGrantIn = 4'b1111;
    tick(); tick();
    tag = "R5";
    busGrantIn = 4'b1011; tick();
    tag = "R4";
    busGrantIn = 4'b0100; bbsyIn = 0; tick();
    busGrantIn = 0; tick();
    // R6: release when done
    tag = "R6";
    devWantBus = 0; tick(); tick();

    // R3: fair request waits for own level to go quiet
    tag = "R3";
    cfgFair = 1; cfgLevel = 2'd1; busReqIn = 4'b0010; devWantBus = 1;
    tick(); tick(); tick();
    busReqIn = 4'b1101; tick(); tick();
    // R10: level change during request does not move line
    tag = "R10";
    cfgLevel = 2'd0; tick();
    busGrantIn = 4'b0001; tick();
    busGrantIn = 4'b0010; busReqIn = 0; tick();
    busGrantIn = 0; devWantBus = 0; tick();

    // R7: release on request, someone waiting
    tag = "R7";
    cfgFair = 0; cfgRelOnReq = 1;
    gainBus(2'd3);
    busReqIn = 4'b1000; devWantBus = 0; tick(); tick();
    busReqIn = 0; tick();

    // R8: keep bus, reuse without arbitration
    tag = "R8";
    gainBus(2'd0);
    devWantBus = 0; tick(); tick();
    busGrantIn = 4'b0001; tick();
    busGrantIn = 0; devWantBus = 1; tick(); tick();
    devWantBus = 0; tick();
    // R9: kept bus released once another master asks
    tag = "R9";
    busReqIn = 4'b0100; tick(); tick();
    toIdle();

    // Random traffic against the reference model (all requirements)
    tag = "RND R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int c = 0; c < 4000; c++) begin
      if (mState == S_IDLE && ($urandom % 16) == 0) begin
        cfgFair = 1'($urandom); cfgRelOnReq = 1'($urandom);
      end
      cfgLevel   = 2'($urandom);
      busReqIn   = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      busGrantIn = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
      bbsyIn     = (($urandom % 4) == 0);
      case (mState)
        S_IDLE, S_KEEP: devWantBus = (($urandom % 3) == 0);
        S_WAIT:         devWantBus = (($urandom % 8) != 0);
        S_REQ:          devWantBus = 1;
        default:        devWantBus = (($urandom % 3) != 0);
      endcase
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule